// File: doc/BRIEF.md
# UART Event Identification Unit

This block gathers the interrupt-worthy events of a UART channel and presents them through one read-only identification register. The sources are receive data at or above its level, receive timeout, transmit data at or below its level, line status, modem status, DMA service and transmitter empty. Each source has a sticky pending flag. The flag sets on a one-cycle event pulse and clears when the matching acknowledge strobe arrives. The channel's register decoder supplies these strobes whenever the related status or data register is accessed.

A mode input selects how the identification register is read. In the legacy view, the flags are masked by a four-bit enable register and priority-encoded into a 16550-style four-bit code. Bit 0 of that code is high when nothing enabled is pending. In the extended view, every flag has its own bit, and the flags set whatever the enables hold. The two views have different clear-on-read side effects. A legacy read removes the transmit-level indication when that indication is the one being reported. An extended read removes the DMA flag when the single-cycle 8237-style DMA option is selected. The interrupt output is high while any enabled source is pending.

Top module: `uart_evt_id`

## Requirements
- R1: After reset the enable register reads 00h and no source is pending except transmit-low and transmitter-empty. The identification register therefore reads 22h in the extended view and 01h in the legacy view.
- R2: The enable register keeps written bits [3:0]: bit 0 enables receive level/timeout, bit 1 transmit low, bit 2 line status and bit 3 modem status. All higher bits read 0.
- R3: The legacy view codes in bits [3:0] are 0110 for line status, 0100 for receive level, 1100 for receive timeout, 0010 for transmit low and 0000 for modem status. Bits above 3 read 0.
- R4: The legacy view picks the highest-priority enabled pending source. The order is line status, receive level, receive timeout, transmit low, then modem status. With nothing enabled and pending it reads 0001.
- R5: The extended view is laid out as follows: bit 0 is receive level or timeout, bit 1 transmit low, bit 2 line status, bit 3 modem status, bit 4 DMA, bit 5 transmitter empty. All higher bits read 0, and the flags show whatever the enables hold.
- R6: In the extended view, reading the identification register clears the DMA flag only when `dma_8237` is high. The `dma_ack` strobe clears it in any mode.
- R7: Receive flags clear on `rx_rd`, line status on `lsr_rd`, modem status on `msr_rd`, and transmit low and transmitter empty on `thr_wr`. Reading the identification register in the extended view clears none of them.
- R8: In the legacy view, reading the identification register clears transmit low only while 0010 is the reported code. A read that reports another code leaves it pending.
- R9: `irq` is high exactly when an enabled one of the four maskable sources is pending, in both views.
- R10: An event pulse in the same cycle as its acknowledge leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects the flat extended view |
| dma_8237 | input | 1 | 1 selects clear-on-identification-read for the DMA flag |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | DW | Enable register write data |
| en_rdata | output | DW | Enable register read data |
| id_rd | input | 1 | Read strobe for the identification register |
| id_rdata | output | DW | Identification register read data |
| rx_rd | input | 1 | Receive data read, acknowledges receive level and timeout |
| thr_wr | input | 1 | Transmit holding write, acknowledges transmit low and empty |
| lsr_rd | input | 1 | Line status read, acknowledges line status |
| msr_rd | input | 1 | Modem status read, acknowledges modem status |
| dma_ack | input | 1 | DMA service acknowledge |
| ev_rx_lvl | input | 1 | Receive level reached event |
| ev_rx_tmo | input | 1 | Receive timeout event |
| ev_tx_low | input | 1 | Transmit low level event |
| ev_line | input | 1 | Line status event |
| ev_modem | input | 1 | Modem status event |
| ev_dma | input | 1 | DMA event |
| ev_tx_empty | input | 1 | Transmitter empty event |
| irq | output | 1 | Interrupt request |

## Verification
The encoder is swept over all 32 combinations of the five prioritised sources against all 16 enable values. Each combination is read in both views. This separates a wrong priority order, a wrong code, a missing mask and a wrong bit position. Directed sequences then cover the clear rules: a legacy read while a higher source masks transmit low, an extended read with and without the DMA option, and an event that collides with its own acknowledge.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
   localparam int NSRC    = 7;
   localparam int SRC_RXL = 0;
   localparam int SRC_RXT = 1;
   localparam int SRC_TXL = 2;
   localparam int SRC_LS  = 3;
   localparam int SRC_MS  = 4;
   localparam int SRC_DMA = 5;
   localparam int SRC_TXE = 6;

   localparam logic [3:0] CODE_LS   = 4'b0110;
   localparam logic [3:0] CODE_RXL  = 4'b0100;
   localparam logic [3:0] CODE_RXT  = 4'b1100;
   localparam logic [3:0] CODE_TXL  = 4'b0010;
   localparam logic [3:0] CODE_MS   = 4'b0000;
   localparam logic [3:0] CODE_NONE = 4'b0001;
endpackage

// File: rtl/uart_evt_flag.sv
module uart_evt_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RST_VAL;
      else if (set) q <= 1'b1;     // event beats acknowledge
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/uart_evt_prio.sv
module uart_evt_prio
   import uart_evt_pkg::*;
(
   input  logic [NSRC-1:0] pend,
   input  logic [3:0]      en,
   output logic [3:0]      code,
   output logic            hit
);
   always_comb begin
      hit  = 1'b1;
      if (pend[SRC_LS] && en[2])       code = CODE_LS;
      else if (pend[SRC_RXL] && en[0]) code = CODE_RXL;
      else if (pend[SRC_RXT] && en[0]) code = CODE_RXT;
      else if (pend[SRC_TXL] && en[1]) code = CODE_TXL;
      else if (pend[SRC_MS] && en[3])  code = CODE_MS;
      else begin
         code = CODE_NONE;
         hit  = 1'b0;
      end
   end
endmodule

// File: rtl/uart_evt_id.sv
module uart_evt_id
   import uart_evt_pkg::*;
#(
   parameter int              DW       = 8,
   parameter logic [NSRC-1:0] RST_PEND = (NSRC'(1) << SRC_TXL) | (NSRC'(1) << SRC_TXE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ext_mode,
   input  logic          dma_8237,
   input  logic          en_wr,
   input  logic [DW-1:0] en_wdata,
   output logic [DW-1:0] en_rdata,
   input  logic          id_rd,
   output logic [DW-1:0] id_rdata,
   input  logic          rx_rd,
   input  logic          thr_wr,
   input  logic          lsr_rd,
   input  logic          msr_rd,
   input  logic          dma_ack,
   input  logic          ev_rx_lvl,
   input  logic          ev_rx_tmo,
   input  logic          ev_tx_low,
   input  logic          ev_line,
   input  logic          ev_modem,
   input  logic          ev_dma,
   input  logic          ev_tx_empty,
   output logic          irq
);
   localparam int EW = 4;
   localparam int XW = 8;

   if (DW < XW) begin : g_bad_dw
      $error("uart_evt_id: DW must be at least 8");
   end

   logic [EW-1:0]   en_q;
   logic [NSRC-1:0] pend_q, set_v, clr_v;
   logic [3:0]      code;
   logic            hit;
   logic [XW-1:0]   ext_v, leg_v;

   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= en_wdata[EW-1:0];
   end

   assign set_v = {ev_tx_empty, ev_dma, ev_modem, ev_line, ev_tx_low, ev_rx_tmo, ev_rx_lvl};

   always_comb begin
      clr_v          = '0;
      clr_v[SRC_RXL] = rx_rd;
      clr_v[SRC_RXT] = rx_rd;
      clr_v[SRC_TXL] = thr_wr | (id_rd & ~ext_mode & (code == CODE_TXL));
      clr_v[SRC_LS]  = lsr_rd;
      clr_v[SRC_MS]  = msr_rd;
      clr_v[SRC_DMA] = dma_ack | (id_rd & ext_mode & dma_8237);
      clr_v[SRC_TXE] = thr_wr;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      uart_evt_flag #(.RST_VAL(RST_PEND[i])) u_flag (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (set_v[i]),
         .clr  (clr_v[i]),
         .q    (pend_q[i])
      );
   end

   uart_evt_prio u_prio (
      .pend(pend_q),
      .en  (en_q),
      .code(code),
      .hit (hit)
   );

   assign ext_v = {2'b00, pend_q[SRC_TXE], pend_q[SRC_DMA], pend_q[SRC_MS],
                   pend_q[SRC_LS], pend_q[SRC_TXL], pend_q[SRC_RXL] | pend_q[SRC_RXT]};
   assign leg_v = {4'b0000, code};

   if (DW > XW) begin : g_pad
      assign id_rdata = {{(DW-XW){1'b0}}, ext_mode ? ext_v : leg_v};
   end else begin : g_nopad
      assign id_rdata = ext_mode ? ext_v : leg_v;
   end

   assign en_rdata = {{(DW-EW){1'b0}}, en_q};
   assign irq      = hit;
endmodule

// File: rtl/uart_evt_id_chk.sv
module uart_evt_id_chk
   import uart_evt_pkg::*;
#(
   parameter int DW = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ext_mode,
   input logic            dma_8237,
   input logic            id_rd,
   input logic [DW-1:0]   id_rdata,
   input logic [DW-1:0]   en_rdata,
   input logic            irq,
   input logic            ev_line,
   input logic            lsr_rd,
   input logic            ev_dma,
   input logic [NSRC-1:0] pend_q,
   input logic [3:0]      en_q
);
   assert_en_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en_rdata[DW-1:4] == '0);

   assert_line_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_mode && pend_q[SRC_LS] && en_q[2]) |-> id_rdata[3:0] == CODE_LS);

   assert_ext_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |-> id_rdata[DW-1:6] == '0);

   assert_dma_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mode && id_rd && dma_8237 && !ev_dma) |=> !pend_q[SRC_DMA]);

   assert_line_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ev_line) |=> !pend_q[SRC_LS]);

   assert_irq_matches_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_mode |-> (irq == !id_rdata[0]));

   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_line |=> pend_q[SRC_LS]);
endmodule

bind uart_evt_id uart_evt_id_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ext_mode(ext_mode),
   .dma_8237(dma_8237),
   .id_rd   (id_rd),
   .id_rdata(id_rdata),
   .en_rdata(en_rdata),
   .irq     (irq),
   .ev_line (ev_line),
   .lsr_rd  (lsr_rd),
   .ev_dma  (ev_dma),
   .pend_q  (pend_q),
   .en_q    (en_q)
);

// File: tb/uart_evt_id_tb.sv
module uart_evt_id_tb;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_mode = 1'b0, dma_8237 = 1'b0, en_wr = 1'b0, id_rd = 1'b0;
   logic [DW-1:0] en_wdata = '0;
   logic [DW-1:0] en_rdata, id_rdata;
   logic rx_rd = 0, thr_wr = 0, lsr_rd = 0, msr_rd = 0, dma_ack = 0;
   logic ev_rx_lvl = 0, ev_rx_tmo = 0, ev_tx_low = 0, ev_line = 0, ev_modem = 0;
   logic ev_dma = 0, ev_tx_empty = 0;
   logic irq;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_evt_id #(.DW(DW)) u_dut (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got %0d cycles exp <150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h exp %h", tag, act, exp);
      end
   endtask

   // one clock edge, then drop every strobe and event
   task automatic step();
      @(negedge clk);
      en_wr = 0; id_rd = 0; rx_rd = 0; thr_wr = 0; lsr_rd = 0; msr_rd = 0; dma_ack = 0;
      ev_rx_lvl = 0; ev_rx_tmo = 0; ev_tx_low = 0; ev_line = 0; ev_modem = 0;
      ev_dma = 0; ev_tx_empty = 0;
      #1;
   endtask

   task automatic clear_all();
      rx_rd = 1; thr_wr = 1; lsr_rd = 1; msr_rd = 1; dma_ack = 1;
      step();
   endtask

   task automatic set_en(input logic [3:0] e);
      en_wr = 1; en_wdata = {4'hF, e};
      step();
   endtask

   function automatic logic [3:0] exp_code(input logic [4:0] s, input logic [3:0] e);
      // s: {ms, ls, txl, rxt, rxl}
      if (s[3] && e[2])      return 4'b0110;
      else if (s[0] && e[0]) return 4'b0100;
      else if (s[1] && e[0]) return 4'b1100;
      else if (s[2] && e[1]) return 4'b0010;
      else if (s[4] && e[3]) return 4'b0000;
      else                   return 4'b0001;
   endfunction

   initial begin
      step(); step();
      rst_n = 1;
      step();
      // R1 reset values
      chk("R1 enable reset", en_rdata, 8'h00);
      chk("R1 legacy reset", id_rdata, 8'h01);
      chk("R1 irq reset", {7'd0, irq}, 8'h00);
      ext_mode = 1; #1;
      chk("R1 extended reset", id_rdata, 8'h22);
      ext_mode = 0; #1;

      // R2 enable register width
      en_wr = 1; en_wdata = 8'hFF; step();
      chk("R2 enable readback", en_rdata, 8'h0F);
      en_wr = 1; en_wdata = 8'hA5; step();
      chk("R2 enable readback", en_rdata, 8'h05);

      // R3 R4 R5 R9 sweep
      for (int e = 0; e < 16; e++) begin
         for (int s = 0; s < 32; s++) begin
            clear_all();
            set_en(4'(e));
            ev_rx_lvl = s[0]; ev_rx_tmo = s[1]; ev_tx_low = s[2];
            ev_line = s[3]; ev_modem = s[4];
            step();
            begin
               logic [3:0] c;
               logic [3:0] eb;
               eb = 4'(e);
               c = exp_code(5'(s), eb);
               chk("R3 R4 legacy code", id_rdata, {4'h0, c});
               chk("R9 irq legacy", {7'd0, irq}, {7'd0, c != 4'b0001});
               ext_mode = 1; #1;
               chk("R5 extended layout", id_rdata,
                   {2'b00, 1'b0, 1'b0, s[4] ? 1'b1 : 1'b0, s[3] ? 1'b1 : 1'b0,
                    s[2] ? 1'b1 : 1'b0, (s[0] | s[1]) ? 1'b1 : 1'b0});
               chk("R9 irq extended", {7'd0, irq}, {7'd0, c != 4'b0001});
               ext_mode = 0; #1;
            end
         end
      end

      // R6 DMA flag clear rules
      clear_all();
      ext_mode = 1; dma_8237 = 0;
      ev_dma = 1; step();
      chk("R6 dma set", id_rdata, 8'h10);
      id_rd = 1; step();
      chk("R6 read without 8237 keeps dma", id_rdata, 8'h10);
      dma_8237 = 1; id_rd = 1; step();
      chk("R6 read with 8237 clears dma", id_rdata, 8'h00);
      ev_dma = 1; step();
      dma_8237 = 0; dma_ack = 1; step();
      chk("R6 dma_ack clears dma", id_rdata, 8'h00);

      // R7 extended read does not clear other flags; acks do
      ev_modem = 1; ev_line = 1; ev_rx_tmo = 1; ev_tx_empty = 1; ev_tx_low = 1; step();
      id_rd = 1; step();
      chk("R7 extended read keeps flags", id_rdata, 8'h2F);
      msr_rd = 1; step();
      chk("R7 msr_rd clears modem", id_rdata, 8'h27);
      lsr_rd = 1; step();
      chk("R7 lsr_rd clears line", id_rdata, 8'h23);
      rx_rd = 1; step();
      chk("R7 rx_rd clears receive", id_rdata, 8'h22);
      thr_wr = 1; step();
      chk("R7 thr_wr clears transmit", id_rdata, 8'h00);
      ext_mode = 0; #1;

      // R8 legacy read clears transmit low only when reported
      set_en(4'b0110);
      ev_tx_low = 1; ev_line = 1; step();
      chk("R8 line reported first", id_rdata, 8'h06);
      id_rd = 1; step();
      chk("R8 read of line keeps tx low", id_rdata, 8'h06);
      lsr_rd = 1; step();
      chk("R8 tx low now reported", id_rdata, 8'h02);
      id_rd = 1; step();
      chk("R8 read of tx low clears it", id_rdata, 8'h01);
      chk("R9 irq drops", {7'd0, irq}, 8'h00);

      // R10 event collides with acknowledge
      set_en(4'b1000);
      ev_modem = 1; msr_rd = 1; step();
      chk("R10 modem event wins over ack", id_rdata, 8'h00);
      chk("R10 irq held", {7'd0, irq}, 8'h01);
      msr_rd = 1; step();
      chk("R10 later ack clears", id_rdata, 8'h01);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule